// File: doc/BRIEF.md
# Nonce Sweep Controller

This block drives a proof-of-work search over an 80-byte block header. Software fills the header one byte at a time while the block is idle, then gives a first nonce, a last nonce and a difficulty, and pulses `go`. The controller steps through the nonces in ascending order. For each one it writes the value into the header's nonce field and pulses `hash_start` to an external double SHA-256 engine, which hashes the header and then hashes that result. The controller waits for `hash_done` and counts the leading zero bits of the returned digest.

The search stops at the first nonce whose digest has at least the required number of leading zeros. That nonce is reported on `win_nonce` with `found` set. If no nonce in the range passes, `exhausted` is set. The sweep visits every value of the inclusive range exactly once and never wraps past the last nonce, even when the last nonce is all ones. An `abort` input stops a search at any point.

Top module: `nonce_sweep_ctrl`

## Requirements
- R1: After reset `busy`, `found`, `exhausted` and `hash_start` are 0, `win_nonce` is 0 and every header byte is 0.
- R2: When `busy` is 0, a write with `hdr_we` high stores `hdr_wdata` into header byte `hdr_addr` (0 to 79). Byte k appears on `header[8k+7:8k]`. Writes to addresses 80 and above are ignored, and so are writes made while `busy` is 1.
- R3: Before each `hash_start` pulse, the current nonce is held in header bytes 76 to 79 in little-endian order, with the least significant byte at 76. Bytes 0 to 75 keep their written values.
- R4: Each nonce gets exactly one `hash_start` pulse, one cycle wide. The nonces run upward from the start value, and the next pulse comes only after `hash_done` for the previous one.
- R5: A digest passes when its count of leading zeros, counted from bit 255 downward, is at least the difficulty. Difficulty 0 passes every digest. Difficulty 256 passes only an all-zero digest. A difficulty above 256 passes nothing.
- R6: On the first passing nonce, `busy` falls, `found` is 1 and `win_nonce` holds that nonce. No further `hash_start` is issued.
- R7: The range is inclusive. If the last nonce fails, `busy` falls with `exhausted` set and `found` clear. A last nonce of 0xFFFFFFFF ends the search without wrapping to 0.
- R8: If the start value is greater than the end value, `exhausted` is set and no `hash_start` is issued.
- R9: With `abort` high, `busy` is 0 on the next cycle and no further `hash_start` follows. `found` and `exhausted` are left as they were.
- R10: A `go` accepted while idle clears `found` and `exhausted`. The two flags are never both set. While the block is idle and `go` is low, `found`, `exhausted` and `win_nonce` hold their values.
- R11: The start, end and difficulty inputs are captured when `go` is accepted. Changing them during a search has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr_we | input | 1 | Header byte write strobe |
| hdr_addr | input | 7 | Header byte address |
| hdr_wdata | input | 8 | Header byte write data |
| cfg_start | input | 32 | First nonce of the range |
| cfg_end | input | 32 | Last nonce of the range, inclusive |
| cfg_diff | input | 9 | Required leading-zero count |
| go | input | 1 | Start a search (accepted when idle) |
| abort | input | 1 | Return to idle |
| hash_start | output | 1 | One-cycle request to the hash engine |
| hash_done | input | 1 | Hash engine result valid |
| hash_digest | input | 256 | Double-hash digest, bit 255 first |
| header | output | 640 | Stored header with the current nonce |
| busy | output | 1 | Search in progress |
| found | output | 1 | Last search ended on a passing nonce |
| exhausted | output | 1 | Last search ended without a pass |
| win_nonce | output | 32 | Passing nonce |

## Verification
A model engine in the bench derives each digest from the nonce it reads out of the header. The leading-zero count is a modular function of the nonce, and every nonce ending in hex F gives an all-zero digest. A sweep over 25 difficulties and shifted 30-nonce windows separates first-hit selection from later hits and from exhaustion, and the hash-start count shows whether any nonce was skipped or repeated. Edge runs cover difficulty 256, difficulty 257, a window that ends at 0xFFFFFFFF (where a wrap would show as extra starts), a reversed range, a one-nonce range and an abort in mid-search. During every search the bench changes the configuration and writes to the header, so that both a missing capture at `go` and a missing write lock show up in the result.

// File: rtl/nsc_pkg.sv
package nsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LOAD    = 3'd1,
        ST_START   = 3'd2,
        ST_WAIT    = 3'd3,
        ST_CHECK   = 3'd4,
        ST_NEXT    = 3'd5,
        ST_FOUND   = 3'd6,
        ST_EXHAUST = 3'd7
    } nsc_state_e;

endpackage

// File: rtl/nsc_hdr_store.sv
module nsc_hdr_store #(
    parameter int HDR_BYTES = 80,
    parameter int NONCE_OFS = 76,
    parameter int NONCE_W   = 32,
    localparam int AW       = $clog2(HDR_BYTES),
    localparam int NB       = NONCE_W / 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_allow,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [7:0]             wr_data,
    input  logic                   nonce_we,
    input  logic [NONCE_W-1:0]     nonce_val,
    output logic [8*HDR_BYTES-1:0] hdr_flat
);

    logic bus_hit_ok;
    assign bus_hit_ok = wr_allow && wr_en;

    for (genvar k = 0; k < HDR_BYTES; k++) begin : g_byte
        logic [7:0] byte_d;
        logic [7:0] byte_q;

        if (k >= NONCE_OFS && k < NONCE_OFS + NB) begin : g_nonce
            localparam int LANE = k - NONCE_OFS;
            always_comb begin
                byte_d = byte_q;
                if (bus_hit_ok && wr_addr == AW'(k)) begin
                    byte_d = wr_data;
                end
                if (nonce_we) begin
                    byte_d = nonce_val[8*LANE +: 8];
                end
            end
        end else begin : g_plain
            always_comb begin
                byte_d = byte_q;
                if (bus_hit_ok && wr_addr == AW'(k)) begin
                    byte_d = wr_data;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else begin
                byte_q <= byte_d;
            end
        end

        assign hdr_flat[8*k +: 8] = byte_q;
    end

endmodule

// File: rtl/nsc_lzc.sv
module nsc_lzc #(
    parameter int W  = 256,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);

    // Ascending scan: the highest set bit is the last one assigned.
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                cnt = CW'(W - 1 - i);
            end
        end
    end

endmodule

// File: rtl/nsc_sweep_fsm.sv
module nsc_sweep_fsm
    import nsc_pkg::*;
#(
    parameter int NONCE_W  = 32,
    parameter int DIGEST_W = 256,
    localparam int DW      = $clog2(DIGEST_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic               abort,
    input  logic [NONCE_W-1:0] cfg_start,
    input  logic [NONCE_W-1:0] cfg_end,
    input  logic [DW-1:0]      cfg_diff,
    input  logic               hash_done,
    input  logic [DW-1:0]      lz_cnt,
    output logic               hash_start,
    output logic               nonce_we,
    output logic [NONCE_W-1:0] nonce_val,
    output logic               busy,
    output logic               found,
    output logic               exhausted,
    output logic [NONCE_W-1:0] win_nonce
);

    typedef struct packed {
        nsc_state_e         state;
        logic [NONCE_W-1:0] cur;
        logic [NONCE_W-1:0] last;
        logic [DW-1:0]      diff;
        logic               hit;
        logic               found;
        logic               exhausted;
        logic [NONCE_W-1:0] win;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d    = fsm_q;
        nonce_we = 1'b0;
        if (abort) begin
            fsm_d.state = ST_IDLE;
        end else begin
            case (fsm_q.state)
                ST_IDLE: begin
                    if (go) begin
                        fsm_d.found     = 1'b0;
                        fsm_d.exhausted = 1'b0;
                        fsm_d.cur       = cfg_start;
                        fsm_d.last      = cfg_end;
                        fsm_d.diff      = cfg_diff;
                        fsm_d.state     = (cfg_start > cfg_end) ? ST_EXHAUST : ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    nonce_we    = 1'b1;
                    fsm_d.state = ST_START;
                end
                ST_START: begin
                    fsm_d.state = ST_WAIT;
                end
                ST_WAIT: begin
                    if (hash_done) begin
                        fsm_d.hit   = (lz_cnt >= fsm_q.diff);
                        fsm_d.state = ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (fsm_q.hit) begin
                        fsm_d.state = ST_FOUND;
                    end else if (fsm_q.cur == fsm_q.last) begin
                        fsm_d.state = ST_EXHAUST;
                    end else begin
                        fsm_d.state = ST_NEXT;
                    end
                end
                ST_NEXT: begin
                    fsm_d.cur   = fsm_q.cur + 1'b1;
                    fsm_d.state = ST_LOAD;
                end
                ST_FOUND: begin
                    fsm_d.found = 1'b1;
                    fsm_d.win   = fsm_q.cur;
                    fsm_d.state = ST_IDLE;
                end
                ST_EXHAUST: begin
                    fsm_d.exhausted = 1'b1;
                    fsm_d.state     = ST_IDLE;
                end
                default: begin
                    fsm_d.state = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign hash_start = (fsm_q.state == ST_START);
    assign nonce_val  = fsm_q.cur;
    assign busy       = (fsm_q.state != ST_IDLE);
    assign found      = fsm_q.found;
    assign exhausted  = fsm_q.exhausted;
    assign win_nonce  = fsm_q.win;

endmodule

// File: rtl/nonce_sweep_ctrl.sv
module nonce_sweep_ctrl #(
    parameter int NONCE_W   = 32,
    parameter int HDR_BYTES = 80,
    parameter int NONCE_OFS = 76,
    parameter int DIGEST_W  = 256,
    localparam int AW       = $clog2(HDR_BYTES),
    localparam int DW       = $clog2(DIGEST_W + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hdr_we,
    input  logic [AW-1:0]          hdr_addr,
    input  logic [7:0]             hdr_wdata,
    input  logic [NONCE_W-1:0]     cfg_start,
    input  logic [NONCE_W-1:0]     cfg_end,
    input  logic [DW-1:0]          cfg_diff,
    input  logic                   go,
    input  logic                   abort,
    output logic                   hash_start,
    input  logic                   hash_done,
    input  logic [DIGEST_W-1:0]    hash_digest,
    output logic [8*HDR_BYTES-1:0] header,
    output logic                   busy,
    output logic                   found,
    output logic                   exhausted,
    output logic [NONCE_W-1:0]     win_nonce
);

    logic               nonce_we;
    logic [NONCE_W-1:0] nonce_val;
    logic [DW-1:0]      lz_cnt;

    nsc_lzc #(
        .W (DIGEST_W)
    ) u_lzc (
        .vec (hash_digest),
        .cnt (lz_cnt)
    );

    nsc_sweep_fsm #(
        .NONCE_W  (NONCE_W),
        .DIGEST_W (DIGEST_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .abort      (abort),
        .cfg_start  (cfg_start),
        .cfg_end    (cfg_end),
        .cfg_diff   (cfg_diff),
        .hash_done  (hash_done),
        .lz_cnt     (lz_cnt),
        .hash_start (hash_start),
        .nonce_we   (nonce_we),
        .nonce_val  (nonce_val),
        .busy       (busy),
        .found      (found),
        .exhausted  (exhausted),
        .win_nonce  (win_nonce)
    );

    nsc_hdr_store #(
        .HDR_BYTES (HDR_BYTES),
        .NONCE_OFS (NONCE_OFS),
        .NONCE_W   (NONCE_W)
    ) u_hdr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_allow  (!busy),
        .wr_en     (hdr_we),
        .wr_addr   (hdr_addr),
        .wr_data   (hdr_wdata),
        .nonce_we  (nonce_we),
        .nonce_val (nonce_val),
        .hdr_flat  (header)
    );

endmodule

// File: rtl/nsc_checker.sv
module nsc_checker #(
    parameter int NONCE_W   = 32,
    parameter int HDR_BYTES = 80
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   go,
    input logic                   abort,
    input logic                   hash_start,
    input logic [8*HDR_BYTES-1:0] header,
    input logic                   busy,
    input logic                   found,
    input logic                   exhausted,
    input logic [NONCE_W-1:0]     win_nonce
);

    p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hash_start |=> !hash_start);

    p_start_while_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hash_start |-> busy);

    p_abort_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && !hash_start));

    p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(found && exhausted));

    p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !go) |=> ($stable(found) && $stable(exhausted) && $stable(win_nonce)));

    p_outcome_on_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(abort)) |-> (found || exhausted));

    p_header_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hash_start |=> $stable(header));

endmodule

bind nonce_sweep_ctrl nsc_checker #(
    .NONCE_W   (NONCE_W),
    .HDR_BYTES (HDR_BYTES)
) u_nsc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .abort      (abort),
    .hash_start (hash_start),
    .header     (header),
    .busy       (busy),
    .found      (found),
    .exhausted  (exhausted),
    .win_nonce  (win_nonce)
);

// File: tb/nonce_sweep_ctrl_test.sv
`timescale 1ns/1ps
module nonce_sweep_ctrl_test;

    localparam int HB = 80;
    localparam int AW = 7;
    localparam int DW = 9;
    localparam int DG = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hdr_we = 1'b0;
    logic [AW-1:0] hdr_addr = '0;
    logic [7:0]    hdr_wdata = '0;
    logic [31:0]   cfg_start = '0;
    logic [31:0]   cfg_end = '0;
    logic [DW-1:0] cfg_diff = '0;
    logic          go = 1'b0;
    logic          abort = 1'b0;
    logic          hash_start;
    logic          hash_done = 1'b0;
    logic [DG-1:0] hash_digest = '0;
    logic [8*HB-1:0] header;
    logic          busy, found, exhausted;
    logic [31:0]   win_nonce;

    int n_checks = 0;
    int n_fail = 0;
    int starts_seen = 0;
    logic [31:0] run_s = '0;
    logic [7:0] img [HB];

    always #2 clk = ~clk;

    nonce_sweep_ctrl uut (
        .clk(clk), .rst_n(rst_n), .hdr_we(hdr_we), .hdr_addr(hdr_addr),
        .hdr_wdata(hdr_wdata), .cfg_start(cfg_start), .cfg_end(cfg_end),
        .cfg_diff(cfg_diff), .go(go), .abort(abort), .hash_start(hash_start),
        .hash_done(hash_done), .hash_digest(hash_digest), .header(header),
        .busy(busy), .found(found), .exhausted(exhausted), .win_nonce(win_nonce)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    function automatic int lz_of(input logic [31:0] n);
        longint unsigned v;
        if (n[3:0] == 4'hF) return 256;
        v = 64'(n);
        return int'((v * 5 + (v >> 4)) % 23);
    endfunction

    function automatic logic [DG-1:0] digest_of(input logic [31:0] n);
        return {DG{1'b1}} >> lz_of(n);
    endfunction

    // Model engine: reads the nonce out of bytes 76..79, answers after 2 cycles
    initial begin
        forever begin
            @(negedge clk);
            if (hash_start) begin
                logic [31:0] nn;
                bit same;
                nn = {header[8*79 +: 8], header[8*78 +: 8], header[8*77 +: 8], header[8*76 +: 8]};
                check(nn == run_s + 32'(starts_seen), "R3/R4", "nonce field at hash_start",
                      64'(nn), 64'(run_s + 32'(starts_seen)));
                same = 1'b1;
                for (int k = 0; k < 76; k++) if (header[8*k +: 8] != img[k]) same = 1'b0;
                check(same, "R3", "bytes 0..75 untouched", 64'(same), 64'd1);
                starts_seen++;
                repeat (2) @(negedge clk);
                hash_digest = digest_of(nn);
                hash_done = 1'b1;
                @(negedge clk);
                hash_done = 1'b0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R4 watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    task automatic run(input logic [31:0] s, input logic [31:0] e, input int d);
        bit exp_found;
        logic [31:0] exp_win;
        int exp_cnt;
        bit same;
        exp_found = 1'b0; exp_win = '0; exp_cnt = 0;
        if (s <= e) begin
            for (longint unsigned n = 64'(s); n <= 64'(e); n++) begin
                exp_cnt++;
                if (lz_of(32'(n)) >= d) begin
                    exp_found = 1'b1; exp_win = 32'(n);
                    break;
                end
            end
        end
        starts_seen = 0;
        run_s = s;
        @(negedge clk);
        cfg_start = s; cfg_end = e; cfg_diff = DW'(d); go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        // R11/R2: disturb configuration and header during the search
        cfg_diff = '0; cfg_end = s; cfg_start = ~s;
        hdr_we = 1'b1; hdr_addr = 7'd10; hdr_wdata = 8'hEE;
        @(negedge clk);
        hdr_we = 1'b0;
        while (busy) @(negedge clk);
        check(found == exp_found, "R6/R11", "found", 64'(found), 64'(exp_found));
        check(exhausted == !exp_found, "R7/R8", "exhausted", 64'(exhausted), 64'(!exp_found));
        if (exp_found) check(win_nonce == exp_win, "R6/R5", "win_nonce", 64'(win_nonce), 64'(exp_win));
        repeat (2) @(negedge clk);
        check(starts_seen == exp_cnt, "R4/R7", "hash_start count", 64'(starts_seen), 64'(exp_cnt));
        same = 1'b1;
        for (int k = 0; k < 76; k++) if (header[8*k +: 8] != img[k]) same = 1'b0;
        check(same, "R2", "write while busy ignored", 64'(same), 64'd1);
    endtask

    initial begin
        bit same;
        int held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0 && hash_start == 1'b0, "R1", "busy/hash_start", 64'({busy, hash_start}), 64'd0);
        check(found == 1'b0 && exhausted == 1'b0, "R1", "flags", 64'({found, exhausted}), 64'd0);
        check(win_nonce == '0 && header == '0, "R1", "win_nonce/header", 64'(win_nonce), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: load header while idle
        for (int k = 0; k < HB; k++) begin
            img[k] = 8'((k * 3 + 1) & 8'hFF);
            hdr_we = 1'b1; hdr_addr = AW'(k); hdr_wdata = img[k];
            @(negedge clk);
        end
        hdr_addr = 7'd100; hdr_wdata = 8'h5A;
        @(negedge clk);
        hdr_we = 1'b0;
        same = 1'b1;
        for (int k = 0; k < HB; k++) if (header[8*k +: 8] != img[k]) same = 1'b0;
        check(same, "R2", "header load and out-of-range write", 64'(same), 64'd1);

        // Sweep of difficulties over shifted windows (R5, R6, R7)
        for (int d = 0; d < 25; d++) begin
            run(32'(d * 37 + 5), 32'(d * 37 + 34), d);
        end
        run(32'h100, 32'h120, 256);               // R5: only all-zero digest
        run(32'h0, 32'd40, 257);                   // R5: unreachable difficulty
        run(32'hFFFF_FFF0, 32'hFFFF_FFFE, 257);    // R7: near top, no hit
        run(32'hFFFF_FFF1, 32'hFFFF_FFFF, 300);    // R7: end at all ones, no wrap
        run(32'hFFFF_FFFE, 32'hFFFF_FFFF, 256);    // R6: hit on the last value
        run(32'd50, 32'd49, 0);                    // R8: reversed range
        run(32'd77, 32'd77, 30);                   // R7: single-nonce range

        // R9: abort in mid-search
        starts_seen = 0;
        run_s = 32'd0;
        @(negedge clk);
        cfg_start = 32'd0; cfg_end = 32'd1000; cfg_diff = DW'(257); go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        repeat (20) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check(busy == 1'b0, "R9", "busy after abort", 64'(busy), 64'd0);
        held = starts_seen;
        repeat (20) @(negedge clk);
        check(starts_seen == held, "R9", "no start after abort", 64'(starts_seen), 64'(held));
        check(found == 1'b0 && exhausted == 1'b0, "R9/R10", "flags after abort",
              64'({found, exhausted}), 64'd0);

        // R10: a new go after abort still completes normally
        run(32'd200, 32'd215, 3);

        summary();
        $finish;
    end

endmodule